// File: doc/BRIEF.md
# Stop-Grant Clock Enable Controller

This block moves a core between running and a low-power stop-grant state. The request to stop is an active-low level, `stop_n`, that arrives with no fixed timing relation to the controller clock. Two flops bring it into the clock domain before any decision uses it.

When the request becomes active, the controller first runs a stop-grant acknowledge handshake on the system bus. It raises `grant_req` and waits for `grant_done`. Only after that handshake does it drop the clock enables of the core units. The bus-interface and interrupt-controller enables are never touched, so snooping and interrupt service keep working while the core sleeps. The bus clock is outside this block and nothing here affects it.

When the request is released, every core enable comes back and `resume` pulses for one cycle. If the release arrives while the handshake is still open, the controller remembers it. When the handshake completes, it goes straight back to running and does not stop at all.

Top module: `stopclk_ctrl`

## Requirements
- R1: Out of reset the block is running: all `core_en` bits are 1, `grant_req`, `sleeping` and `resume` are 0.
- R2: `stop_n` passes through a two-flop synchronizer. A low level applied between two rising edges raises `grant_req` after the third following rising edge, and not earlier.
- R3: `grant_req` stays 1 until `grant_done` is sampled high. While it is 1, every `core_en` bit stays 1.
- R4: If `grant_done` is sampled high during the handshake while the synchronized request is still active, then after that edge `sleeping` is 1, all `core_en` bits are 0 and `grant_req` is 0.
- R5: `bus_en` and `intc_en` are 1 in every cycle, in every state.
- R6: While sleeping, a release of `stop_n` (a high level) is seen after the third following rising edge. At that point `sleeping` is 0, all `core_en` bits are 1 and `resume` is 1 for exactly that one cycle.
- R7: A release seen during the handshake is held. On `grant_done`, the block returns directly to running, with `resume` high for one cycle, without entering the sleeping state.
- R8: `grant_done` sampled outside the handshake, whether running or sleeping, changes no output.
- R9: `sleeping` is 1 exactly when the core enables are gated off, and it is never 1 together with `grant_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| grant_req | output | 1 | Stop-grant acknowledge transaction request |
| grant_done | input | 1 | Acknowledge transaction completed |
| core_en | output | CORE_UNITS | Per-core-unit clock enables |
| bus_en | output | 1 | Bus-interface unit clock enable |
| intc_en | output | 1 | Interrupt-controller unit clock enable |
| sleeping | output | 1 | Status: 1 while in the stop-grant state |
| resume | output | 1 | One-cycle pulse when execution may resume |

## Verification
The properties assume only one thing about the inputs: `grant_done` may come at any time. It may arrive during the handshake, after any delay, or as a stray pulse while running or sleeping. They never assume that `stop_n` lines up with the clock. The bench changes `stop_n` and `grant_done` only on falling edges, so the synchronizer sees clean levels and the latency in R2 and R6 is exact. It sweeps the handshake delay and the release point, and it injects stray `grant_done` pulses in both idle states.

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl #(
  parameter int CORE_UNITS = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_n,
  output logic                  grant_req,
  input  logic                  grant_done,
  output logic [CORE_UNITS-1:0] core_en,
  output logic                  bus_en,
  output logic                  intc_en,
  output logic                  sleeping,
  output logic                  resume
);

  typedef enum logic [1:0] {RUN, GRANT, SLEEP} st_t;

  st_t                   st;
  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  rel_seen;
  logic                  req;

  assign req = ~sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], stop_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RUN;
      rel_seen <= 1'b0;
      resume   <= 1'b0;
    end else begin
      resume <= 1'b0;
      case (st)
        RUN:
          if (req) st <= GRANT;
        GRANT: begin
          if (!req) rel_seen <= 1'b1;
          if (grant_done) begin
            rel_seen <= 1'b0;
            if (rel_seen || !req) begin
              st     <= RUN;
              resume <= 1'b1;
            end else begin
              st <= SLEEP;
            end
          end
        end
        SLEEP:
          if (!req) begin
            st     <= RUN;
            resume <= 1'b1;
          end
        default: st <= RUN;
      endcase
    end
  end

  assign grant_req = (st == GRANT);
  assign sleeping  = (st == SLEEP);
  assign core_en   = {CORE_UNITS{st != SLEEP}};
  assign bus_en    = 1'b1;
  assign intc_en   = 1'b1;

endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk #(
  parameter int CORE_UNITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  grant_req,
  input logic                  grant_done,
  input logic [CORE_UNITS-1:0] core_en,
  input logic                  sleeping,
  input logic                  resume
);

  // R4
  sleep_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(grant_req && grant_done));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_req) |-> $past(grant_done));

  // R3
  grant_core_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_req |-> core_en == {CORE_UNITS{1'b1}});

  // R9
  gated_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping == (core_en == '0));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleeping && grant_req));

  // R6
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // R7
  resume_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!sleeping && !grant_req && $past(sleeping || grant_req)));

endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(.CORE_UNITS(CORE_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_req(grant_req), .grant_done(grant_done),
  .core_en(core_en), .sleeping(sleeping), .resume(resume));

// File: tb/stopclk_ctrl_bench.sv
module stopclk_ctrl_bench;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, stop_n = 1'b1, grant_done = 1'b0;
  logic grant_req, bus_en, intc_en, sleeping, resume;
  logic [N-1:0] core_en;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  stopclk_ctrl #(.CORE_UNITS(N)) u_stopclk_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .grant_req(grant_req),
    .grant_done(grant_done), .core_en(core_en), .bus_en(bus_en),
    .intc_en(intc_en), .sleeping(sleeping), .resume(resume));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R5 bus_en", {31'd0, bus_en}, 1);
    chk("R5 intc_en", {31'd0, intc_en}, 1);
  endtask

  task automatic pulse_done();
    grant_done = 1'b1;
    step();
    grant_done = 1'b0;
  endtask

  task automatic enter_grant();
    stop_n = 1'b0;
    step(); chk("R2 no grant after edge 1", {31'd0, grant_req}, 0);
    step(); chk("R2 no grant after edge 2", {31'd0, grant_req}, 0);
    step(); chk("R2 grant after edge 3", {31'd0, grant_req}, 1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 core_en", {28'd0, core_en}, {28'd0, ALL});
    chk("R1 grant_req", {31'd0, grant_req}, 0);
    chk("R1 sleeping", {31'd0, sleeping}, 0);
    chk("R1 resume", {31'd0, resume}, 0);
    rst_n = 1'b1;
    step();

    for (int d = 0; d < 4; d++) begin
      enter_grant();
      for (int k = 0; k < d; k++) begin
        step();
        chk("R3 grant held", {31'd0, grant_req}, 1);
        chk("R3 core on in grant", {28'd0, core_en}, {28'd0, ALL});
      end
      pulse_done();
      chk("R4 sleeping", {31'd0, sleeping}, 1);
      chk("R4 core gated", {28'd0, core_en}, 0);
      chk("R4 grant dropped", {31'd0, grant_req}, 0);
      pulse_done();
      chk("R8 stray done while sleeping", {31'd0, sleeping}, 1);
      chk("R8 stray done no grant", {31'd0, grant_req}, 0);
      chk("R8 stray done core gated", {28'd0, core_en}, 0);
      stop_n = 1'b1;
      step(); chk("R6 still asleep edge 1", {31'd0, sleeping}, 1);
      step(); chk("R6 still asleep edge 2", {31'd0, sleeping}, 1);
      step();
      chk("R6 awake", {31'd0, sleeping}, 0);
      chk("R6 core on", {28'd0, core_en}, {28'd0, ALL});
      chk("R6 resume pulse", {31'd0, resume}, 1);
      step(); chk("R6 resume one cycle", {31'd0, resume}, 0);
      pulse_done();
      chk("R8 stray done while running", {31'd0, grant_req}, 0);
      chk("R8 running stays", {31'd0, sleeping}, 0);
      chk("R8 no resume", {31'd0, resume}, 0);
    end

    for (int d = 1; d < 5; d++) begin
      enter_grant();
      stop_n = 1'b1;
      for (int k = 0; k < d + 2; k++) begin
        step();
        chk("R7 grant held after release", {31'd0, grant_req}, 1);
        chk("R7 not sleeping", {31'd0, sleeping}, 0);
      end
      pulse_done();
      chk("R7 back to run", {31'd0, sleeping}, 0);
      chk("R7 grant dropped", {31'd0, grant_req}, 0);
      chk("R7 resume", {31'd0, resume}, 1);
      chk("R7 core on", {28'd0, core_en}, {28'd0, ALL});
      step();
      chk("R7 stays running", {31'd0, grant_req}, 0);
      chk("R7 resume one cycle", {31'd0, resume}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule